// File: doc/BRIEF.md
# Two-Wire Controller Byte FIFO Pair

This block holds the transmit and receive bytes of a two-wire serial controller, between a 32-bit register bus and the serial bit engine. The bus pushes transmit bytes and pops receive bytes through two holding addresses. A byte-wide access moves one entry. A word access moves four entries, with the lowest byte lane going first. The bit engine sits on the other side and is modelled here as a plain byte pop port for transmit and a byte push port for receive.

Two mode flags, `txReady` and `rxReady`, tell software or a DMA engine when it may move data. In queue mode each flag fires at a programmable level of one, two or four entries, so a DMA engine can move whole words. With queue mode off, each direction holds a single byte and the flags follow that byte. A control register gives flush, lock release, mode enable and disable, and a soft reset. A level register and a status register with sticky error bits round out the block.

Register offsets: control 0x00 (write only), receive holding 0x30, transmit holding 0x34, mode 0x50, level 0x54, status 0x60. Any other offset reads as zero.

Top module: `twoWireFifoPair`

## Requirements
- R1: After reset both queues are empty, queue mode is off and both thresholds are one entry. `txReady`=1, `rxReady`=0, `txValid`=0, and the mode, level and status registers read 0.
- R2: A byte write to 0x34 pushes `busWdata[7:0]`, and a word write (`busWord`=1) pushes four bytes starting at `[7:0]`. `txData` shows the oldest byte while `txValid` is high, and each cycle with `txPop` high removes that byte.
- R3: A byte read of 0x30 returns the oldest receive byte in `[7:0]` with zeros above it and pops it. A word read pops four bytes, oldest in `[7:0]`.
- R4: With queue mode off, each direction holds at most one byte and the threshold fields have no effect. `txReady` is high only when the transmit side is empty, and `rxReady` is high only when the receive side holds a byte.
- R5: With queue mode on, `txReady` is high when the free transmit entries are at least the threshold in mode bits [1:0]. The codes are 0 for one, 1 for two and 2 for four; code 3 also means four.
- R6: With queue mode on, `rxReady` is high when the held receive entries are at least the threshold in mode bits [5:4], using the same encoding as R5.
- R7: The level register at 0x54 reads the transmit count in bits [5:0] and the receive count in bits [21:16].
- R8: A bus push beyond capacity discards that byte and sets status bit 0. A bus pop from an empty receive side returns zero in that lane and sets status bit 1. Reading status returns these bits and then clears them.
- R9: A pulse on `txLockSet` locks the transmitter, which shows as status bit 2. While locked, `txValid` stays low. Control bit 26 releases the lock.
- R10: Control bit 24 empties the transmit side and bit 25 empties the receive side. Bits 24 and 26 written together empty the transmit side and release the lock.
- R11: Control bit 28 turns queue mode on and bit 29 turns it off; when both are set, bit 29 wins. Status bit 3 shows the mode.
- R12: Control bit 7 is a soft reset. It empties both sides, releases the lock, clears the status error bits, sets both thresholds to one and turns queue mode off.
- R13: A byte arriving on `rxPush` when the receive side is full is dropped and sets sticky status bit 4, which clears on a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Register byte offset |
| busWord | input | 1 | 1 = word access, 0 = byte access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of `busRdEn` |
| txReady | output | 1 | Transmit room flag / DMA request |
| rxReady | output | 1 | Receive data flag / DMA request |
| txData | output | 8 | Oldest transmit byte |
| txValid | output | 1 | A transmit byte is available and the lock is released |
| txPop | input | 1 | Bit engine takes `txData` |
| txLockSet | input | 1 | Bit engine locks the transmitter |
| rxData | input | 8 | Received byte |
| rxPush | input | 1 | Bit engine delivers `rxData` |

## Verification
The assertions assume that the bit engine raises `txPop` only while `txValid` is high. They also assume that a bus cycle is never a read and a write at once, that `txLockSet` never lands in the same cycle as a lock release or soft reset, and that the depth stays between 4 and 63. The directed stimulus drives one bus access per task and pops only bytes it has just seen valid. It pulses the lock only in cycles with no control write, so every scenario stays within those assumptions.

// File: rtl/fifoPairPkg.sv
package fifoPairPkg;
  localparam int LANES = 4;
  localparam int NW = $clog2(LANES + 1);

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RXHOLD = 8'h30;
  localparam logic [7:0] OFS_TXHOLD = 8'h34;
  localparam logic [7:0] OFS_MODE   = 8'h50;
  localparam logic [7:0] OFS_LEVEL  = 8'h54;
  localparam logic [7:0] OFS_STATUS = 8'h60;

  localparam int BIT_SOFTRST = 7;
  localparam int BIT_TXFLUSH = 24;
  localparam int BIT_RXFLUSH = 25;
  localparam int BIT_UNLOCK  = 26;
  localparam int BIT_QON     = 28;
  localparam int BIT_QOFF    = 29;

  typedef struct packed {
    logic [NW-1:0] txPushN;
    logic [NW-1:0] rxPopN;
    logic          txFlush;
    logic          rxFlush;
  } strobeT;
endpackage

// File: rtl/byteQueue.sv
module byteQueue #(
  parameter int DEPTH = 16,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES = 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PUSH_LANES + 1),
  localparam int QW = $clog2(POP_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic [CW-1:0]           cap,
  input  logic [PW-1:0]           pushN,
  input  logic [PUSH_LANES*8-1:0] pushData,
  input  logic [QW-1:0]           popN,
  output logic [CW-1:0]           count,
  output logic [POP_LANES*8-1:0]  headData,
  output logic                    pushDrop,
  output logic                    popShort
);
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] room, pushAcc, popAcc;

  function automatic logic [AW-1:0] wrapAdd(input logic [AW-1:0] p, input int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  always_comb begin
    room     = (cap > count) ? cap - count : '0;
    pushAcc  = (CW'(pushN) <= room) ? CW'(pushN) : room;
    popAcc   = (CW'(popN) <= count) ? CW'(popN) : count;
    pushDrop = CW'(pushN) > room;
    popShort = CW'(popN) > count;
    for (int i = 0; i < POP_LANES; i++)
      headData[8*i +: 8] = (int'(count) > i) ? mem[wrapAdd(rdPtr, i)] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      rdPtr <= wrapAdd(rdPtr, popAcc);
      wrPtr <= wrapAdd(wrPtr, pushAcc);
      count <= count + pushAcc - popAcc;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_LANES; i++)
      if (!flush && i < int'(pushAcc))
        mem[wrapAdd(wrPtr, i)] <= pushData[8*i +: 8];
  end

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R8
endmodule

// File: rtl/fifoDatapath.sv
module fifoDatapath
  import fifoPairPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strobe,
  input  logic          fifoOn,
  input  logic [31:0]   busWdata,
  input  logic          txLocked,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic [7:0]    rxData,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [31:0]   rxWord,
  output logic [7:0]    txData,
  output logic          txValid,
  output logic          txDrop,
  output logic          rxShort,
  output logic          rxLost
);
  logic [CW-1:0] cap;
  logic txPopShort;
  logic txPopReq;

  assign cap      = fifoOn ? CW'(DEPTH) : CW'(1);
  assign txPopReq = txPop && !txLocked;

  byteQueue #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) u_txQ (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush), .cap(cap),
    .pushN(strobe.txPushN), .pushData(busWdata), .popN(txPopReq),
    .count(txCount), .headData(txData), .pushDrop(txDrop), .popShort(txPopShort)
  );

  byteQueue #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) u_rxQ (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush), .cap(cap),
    .pushN(rxPush), .pushData(rxData), .popN(strobe.rxPopN),
    .count(rxCount), .headData(rxWord), .pushDrop(rxLost), .popShort(rxShort)
  );

  assign txValid = (txCount != '0) && !txLocked;

  AST_POP_WHEN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> (txValid && !txPopShort)); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txFlush |=> (txCount == '0)); // R10
  AST_SINGLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoOn && txCount != '0) |=> (txCount <= $past(txCount))); // R4
endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPairPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic [7:0]    busAddr,
  input  logic          busWord,
  input  logic [31:0]   busWdata,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [31:0]   rxWord,
  input  logic          txDrop,
  input  logic          rxShort,
  input  logic          rxLost,
  input  logic          txLockSet,
  output strobeT        strobe,
  output logic          fifoOn,
  output logic          txLocked,
  output logic [31:0]   busRdata,
  output logic          txReady,
  output logic          rxReady
);
  logic [1:0] txThr, rxThr;
  logic txOvf, rxUdf, rxOvr;
  logic ctrlWr, softRst, statusRd;
  logic [NW-1:0] lanes;
  logic [CW-1:0] txFree;

  function automatic logic [CW-1:0] thrOf(input logic [1:0] code);
    case (code)
      2'd0:    return CW'(1);
      2'd1:    return CW'(2);
      default: return CW'(4);
    endcase
  endfunction

  assign ctrlWr   = busWrEn && busAddr == OFS_CTRL;
  assign softRst  = ctrlWr && busWdata[BIT_SOFTRST];
  assign statusRd = busRdEn && busAddr == OFS_STATUS;
  assign lanes    = busWord ? NW'(LANES) : NW'(1);

  always_comb begin
    strobe.txPushN = (busWrEn && busAddr == OFS_TXHOLD) ? lanes : '0;
    strobe.rxPopN  = (busRdEn && busAddr == OFS_RXHOLD) ? lanes : '0;
    strobe.txFlush = ctrlWr && (busWdata[BIT_TXFLUSH] || busWdata[BIT_SOFTRST]);
    strobe.rxFlush = ctrlWr && (busWdata[BIT_RXFLUSH] || busWdata[BIT_SOFTRST]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoOn   <= 1'b0;
      txThr    <= 2'd0;
      rxThr    <= 2'd0;
      txLocked <= 1'b0;
      txOvf    <= 1'b0;
      rxUdf    <= 1'b0;
      rxOvr    <= 1'b0;
    end else begin
      if (softRst || (ctrlWr && busWdata[BIT_QOFF])) fifoOn <= 1'b0;
      else if (ctrlWr && busWdata[BIT_QON])          fifoOn <= 1'b1;

      if (softRst) begin
        txThr <= 2'd0;
        rxThr <= 2'd0;
      end else if (busWrEn && busAddr == OFS_MODE) begin
        txThr <= busWdata[1:0];
        rxThr <= busWdata[5:4];
      end

      if (txLockSet)                                          txLocked <= 1'b1;
      else if (softRst || (ctrlWr && busWdata[BIT_UNLOCK]))   txLocked <= 1'b0;

      if (txDrop)                    txOvf <= 1'b1;
      else if (statusRd || softRst)  txOvf <= 1'b0;
      if (rxShort)                   rxUdf <= 1'b1;
      else if (statusRd || softRst)  rxUdf <= 1'b0;
      if (rxLost)                    rxOvr <= 1'b1;
      else if (statusRd || softRst)  rxOvr <= 1'b0;
    end
  end

  assign txFree  = CW'(DEPTH) - txCount;
  assign txReady = fifoOn ? (txFree >= thrOf(txThr)) : (txCount == '0);
  assign rxReady = fifoOn ? (rxCount >= thrOf(rxThr)) : (rxCount != '0);

  always_comb begin
    busRdata = '0;
    if (busRdEn) begin
      case (busAddr)
        OFS_RXHOLD: busRdata = busWord ? rxWord : {24'h0, rxWord[7:0]};
        OFS_MODE:   busRdata = {26'h0, rxThr, 2'b00, txThr};
        OFS_LEVEL:  busRdata = {10'h0, 6'(rxCount), 10'h0, 6'(txCount)};
        OFS_STATUS: busRdata = {27'h0, rxOvr, fifoOn, txLocked, rxUdf, txOvf};
        default:    busRdata = '0;
      endcase
    end
  end

  AST_SOFTRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !txLockSet) |=> (!fifoOn && txThr == 2'd0 && rxThr == 2'd0 && !txLocked)); // R12
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (txOvf && !statusRd && !softRst) |=> txOvf); // R8
  AST_QOFF_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[BIT_QOFF]) |=> !fifoOn); // R11
endmodule

// File: rtl/twoWireFifoPair.sv
module twoWireFifoPair
  import fifoPairPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busAddr,
  input  logic        busWord,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        txReady,
  output logic        rxReady,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        txPop,
  input  logic        txLockSet,
  input  logic [7:0]  rxData,
  input  logic        rxPush
);
  strobeT strobe;
  logic fifoOn, txLocked, txDrop, rxShort, rxLost;
  logic [CW-1:0] txCount, rxCount;
  logic [31:0] rxWord;

  fifoCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWord(busWord), .busWdata(busWdata),
    .txCount(txCount), .rxCount(rxCount), .rxWord(rxWord),
    .txDrop(txDrop), .rxShort(rxShort), .rxLost(rxLost), .txLockSet(txLockSet),
    .strobe(strobe), .fifoOn(fifoOn), .txLocked(txLocked), .busRdata(busRdata),
    .txReady(txReady), .rxReady(rxReady)
  );

  fifoDatapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fifoOn(fifoOn), .busWdata(busWdata),
    .txLocked(txLocked), .txPop(txPop), .rxPush(rxPush), .rxData(rxData),
    .txCount(txCount), .rxCount(rxCount), .rxWord(rxWord), .txData(txData),
    .txValid(txValid), .txDrop(txDrop), .rxShort(rxShort), .rxLost(rxLost)
  );
endmodule

// File: tb/twoWireFifoPair_bench.sv
module twoWireFifoPair_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_RXH = 8'h30, A_TXH = 8'h34,
                         A_MODE = 8'h50, A_LEVEL = 8'h54, A_STAT = 8'h60;

  logic clk = 0, rstN = 0;
  logic busWrEn = 0, busRdEn = 0, busWord = 0;
  logic [7:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic txReady, rxReady, txValid, txPop = 0, txLockSet = 0, rxPush = 0;
  logic [7:0] txData, rxData = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twoWireFifoPair u_twoWireFifoPair (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWord(busWord), .busWdata(busWdata), .busRdata(busRdata), .txReady(txReady),
    .rxReady(rxReady), .txData(txData), .txValid(txValid), .txPop(txPop),
    .txLockSet(txLockSet), .rxData(rxData), .rxPush(rxPush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWdata = d; busWord = w;
    @(posedge clk); #1;
    busWrEn = 0; busWord = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1; busAddr = a; busWord = w;
    #1 d = busRdata;
    @(posedge clk); #1;
    busRdEn = 0; busWord = 0;
  endtask

  task automatic rxIn(input logic [7:0] b);
    @(negedge clk);
    rxPush = 1; rxData = b;
    @(posedge clk); #1;
    rxPush = 0;
  endtask

  task automatic txOut(output logic [7:0] b);
    @(negedge clk);
    txPop = 1;
    #1 b = txData;
    @(posedge clk); #1;
    txPop = 0;
  endtask

  task automatic lockPulse();
    @(negedge clk);
    txLockSet = 1;
    @(posedge clk); #1;
    txLockSet = 0;
  endtask

  task automatic sreset();
    wr(A_CTRL, 32'h0000_0080, 0);
  endtask

  task automatic tResetState();
    logic [31:0] d;
    chk("R1 txReady", txReady, 1);
    chk("R1 rxReady", rxReady, 0);
    chk("R1 txValid", txValid, 0);
    rd(A_MODE, 1, d);  chk("R1 mode", d, 0);
    rd(A_LEVEL, 1, d); chk("R1 level", d, 0);
    rd(A_STAT, 1, d);  chk("R1 status", d, 0);
  endtask

  task automatic tSingleEntry();
    logic [31:0] d; logic [7:0] b;
    sreset();
    wr(A_TXH, 32'h0000_00A5, 0);
    chk("R4 txReady full", txReady, 0);
    chk("R2 txValid", txValid, 1);
    chk("R2 txData", txData, 8'hA5);
    wr(A_TXH, 32'h0000_0011, 0);
    rd(A_STAT, 1, d); chk("R8 tx overflow sticky", d, 32'h1);
    rd(A_STAT, 1, d); chk("R8 clear on read", d, 32'h0);
    txOut(b); chk("R2 popped byte", b, 8'hA5);
    chk("R4 txReady empty", txReady, 1);
    chk("R2 txValid empty", txValid, 0);
    rxIn(8'h3C); rxIn(8'h44);
    chk("R4 rxReady", rxReady, 1);
    rd(A_STAT, 1, d); chk("R13 rx drop sticky", d, 32'h10);
    rd(A_RXH, 0, d); chk("R3 byte read", d, 32'h3C);
    chk("R4 rxReady empty", rxReady, 0);
  endtask

  task automatic tWordPush();
    logic [31:0] d; logic [7:0] b;
    sreset();
    wr(A_CTRL, 32'h1000_0000, 0);
    rd(A_STAT, 1, d); chk("R11 mode on", d, 32'h8);
    wr(A_TXH, 32'h4433_2211, 1);
    rd(A_LEVEL, 1, d); chk("R7 tx level 4", d, 32'h4);
    for (int i = 1; i <= 4; i++) begin
      txOut(b); chk("R2 word lane order", b, 8'(8'h11 * i));
    end
    wr(A_TXH, 32'h0000_01FF, 0);
    rd(A_LEVEL, 1, d); chk("R2 byte push one entry", d, 32'h1);
    txOut(b); chk("R2 byte lane", b, 8'hFF);
  endtask

  task automatic tTxThreshold();
    logic [31:0] d;
    sreset();
    wr(A_CTRL, 32'h1000_0000, 0);
    wr(A_MODE, 32'h2, 0);
    for (int i = 0; i < 3; i++) wr(A_TXH, 32'h0102_0304, 1);
    chk("R5 four free", txReady, 1);
    wr(A_TXH, 32'h0, 0);
    chk("R5 three free at four", txReady, 0);
    wr(A_MODE, 32'h1, 0);
    chk("R5 three free at two", txReady, 1);
    wr(A_CTRL, 32'h0100_0000, 0);
    rd(A_LEVEL, 1, d); chk("R10 tx flush", d, 32'h0);
  endtask

  task automatic tRxThreshold();
    logic [31:0] d;
    sreset();
    wr(A_CTRL, 32'h1000_0000, 0);
    wr(A_MODE, 32'h20, 0);
    wr(A_TXH, 32'h9, 0);
    for (int i = 1; i <= 3; i++) rxIn(8'(i));
    chk("R6 three held at four", rxReady, 0);
    rxIn(8'h04);
    chk("R6 four held", rxReady, 1);
    rd(A_LEVEL, 1, d); chk("R7 both levels", d, 32'h0004_0001);
    rd(A_RXH, 1, d); chk("R3 word read", d, 32'h0403_0201);
    chk("R6 drained", rxReady, 0);
    rxIn(8'h55);
    wr(A_CTRL, 32'h0200_0000, 0);
    rd(A_LEVEL, 1, d); chk("R10 rx flush", d, 32'h1);
  endtask

  task automatic tErrors();
    logic [31:0] d;
    sreset();
    wr(A_CTRL, 32'h1000_0000, 0);
    rxIn(8'hAA); rxIn(8'hBB);
    rd(A_RXH, 1, d); chk("R8 short word read", d, 32'h0000_BBAA);
    rd(A_STAT, 1, d); chk("R8 underflow", d, 32'hA);
    for (int i = 0; i < 4; i++) wr(A_TXH, 32'hCAFE_F00D, 1);
    rd(A_STAT, 1, d); chk("R8 no overflow at full", d, 32'h8);
    wr(A_TXH, 32'h1, 0);
    rd(A_STAT, 1, d); chk("R8 overflow", d, 32'h9);
    rd(A_LEVEL, 1, d); chk("R8 level capped", d, 32'h10);
    for (int i = 0; i < 17; i++) rxIn(8'(i));
    rd(A_LEVEL, 1, d); chk("R13 rx full level", d, 32'h0010_0010);
    rd(A_STAT, 1, d); chk("R13 rx drop", d, 32'h18);
  endtask

  task automatic tLock();
    logic [31:0] d;
    sreset();
    wr(A_CTRL, 32'h1000_0000, 0);
    wr(A_TXH, 32'h5A, 0);
    lockPulse();
    chk("R9 locked holds", txValid, 0);
    rd(A_STAT, 1, d); chk("R9 lock bit", d, 32'hC);
    wr(A_CTRL, 32'h0500_0000, 0);
    rd(A_LEVEL, 1, d); chk("R10 flush with unlock", d, 32'h0);
    rd(A_STAT, 1, d); chk("R10 unlocked", d, 32'h8);
    wr(A_TXH, 32'h77, 0);
    lockPulse();
    wr(A_CTRL, 32'h0400_0000, 0);
    chk("R9 unlock resumes", txValid, 1);
    chk("R9 data kept", txData, 8'h77);
  endtask

  task automatic tModeOff();
    logic [31:0] d;
    sreset();
    wr(A_CTRL, 32'h3000_0000, 0);
    rd(A_STAT, 1, d); chk("R11 off wins", d, 32'h0);
    wr(A_MODE, 32'h22, 0);
    rxIn(8'h66);
    chk("R4 rx threshold ignored", rxReady, 1);
    chk("R4 tx threshold ignored", txReady, 1);
  endtask

  task automatic tSoftReset();
    logic [31:0] d;
    sreset();
    wr(A_CTRL, 32'h1000_0000, 0);
    wr(A_MODE, 32'h22, 0);
    wr(A_TXH, 32'h12, 0);
    rxIn(8'h34);
    lockPulse();
    sreset();
    rd(A_LEVEL, 1, d); chk("R12 emptied", d, 32'h0);
    rd(A_MODE, 1, d);  chk("R12 thresholds", d, 32'h0);
    rd(A_STAT, 1, d);  chk("R12 status", d, 32'h0);
    chk("R12 txReady", txReady, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tResetState();
    tSingleEntry();
    tWordPush();
    tTxThreshold();
    tRxThreshold();
    tErrors();
    tLock();
    tModeOff();
    tSoftReset();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule